// File: doc/BRIEF.md
# Digit-Serial Decimal Adder

This block adds two unsigned decimal numbers held as packed BCD digits, each `DIGITS` digits wide. It has a single one-digit decimal adder with its add-6 correction, and it uses that adder for every digit position in turn, one digit per clock. A start pulse copies both operands into shift registers and seeds the inter-digit carry flip-flop from `carry_in`. On each following clock, the least significant pending digit pair and the stored carry pass through the digit adder. The corrected digit enters the result register from its most significant end, and the digit carry is kept for the next position.

The result therefore needs `DIGITS` clocks, and the adder costs the logic of one digit. A small state machine has three states. `ST_IDLE` waits for work. `ST_RUN` shifts one digit per cycle. `ST_DONE` lasts one cycle and signals completion. The transitions are: IDLE→RUN on start, RUN→RUN while digits remain, RUN→DONE after the last digit, DONE→RUN on start, DONE→IDLE otherwise. Synchronous reset forces IDLE from any state.

Top module: `bcd_serial_adder`

## Requirements
- R1: When `done` is high, `sum` holds (A + B + carry_in) mod 10^DIGITS as packed BCD, digit k in bits [4k+3:4k], so the least significant digit is in bits [3:0].
- R2: When `done` is high, `carry_out` is 1 exactly when A + B + carry_in ≥ 10^DIGITS.
- R3: After an accepted start, `busy` is high for exactly DIGITS consecutive cycles, starting in the cycle after the start edge.
- R4: `done` is high for exactly one cycle, the cycle right after `busy` falls (state ST_DONE).
- R5: The digit adder adds 6 whenever its raw 5-bit sum has bit 4 set or its low four bits exceed 9. Every result digit it writes is in the range 0 to 9, and its carry goes to the next digit (for example, 9 + 9 + 1 gives digit 9 with carry 1).
- R6: A start pulse while `busy` is high is ignored. The run in progress finishes with its original operands and its original length.
- R7: While neither busy nor being started, `sum` and `carry_out` keep the last completed result.
- R8: Synchronous active-high `rst` clears `busy`, `done`, `sum` and `carry_out` to 0 on the next clock edge, including in the middle of a run.
- R9: The `carry_in` value sampled at an accepted start is the carry into the least significant digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load operands and begin an addition (ignored while busy) |
| carry_in | input | 1 | Carry into the least significant digit, sampled with start |
| opa | input | 4*DIGITS | First operand, packed BCD |
| opb | input | 4*DIGITS | Second operand, packed BCD |
| busy | output | 1 | High while digits are being added |
| done | output | 1 | One-cycle completion pulse |
| sum | output | 4*DIGITS | Result digits, packed BCD |
| carry_out | output | 1 | Final decimal carry (overflow digit) |

## Verification
The assertion on the result digit range assumes that every digit of `opa` and `opb` is a legal BCD code (0 to 9) when start is accepted. The design does not check its inputs, so an illegal code would produce an out-of-range digit. The stimulus keeps to this assumption by building every operand from an integer in 0 to 10^DIGITS − 1 with a digit-by-digit conversion. The sweep covers every operand pair and both carry-in values for a two-digit configuration. Directed runs add a start during busy, a reset in the middle of a run, and idle hold periods.

// File: rtl/bcd_serial_pkg.sv
package bcd_serial_pkg;
    localparam int DW = 4;   // bits per decimal digit

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ser_state_t;
endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
    import bcd_serial_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] s,
    output logic          cout
);
    logic [DW:0]   raw;
    logic          fix;
    logic [DW-1:0] adj;

    always_comb begin
        raw  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
        // correction needed when binary carry or low nibble in 10..15
        fix  = raw[DW] | (raw[3] & (raw[2] | raw[1]));
        adj  = fix ? 4'd6 : 4'd0;
        s    = raw[DW-1:0] + adj;
        cout = fix;
    end
endmodule

// File: rtl/bcd_shift_reg.sv
module bcd_shift_reg
    import bcd_serial_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W = DIGITS * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          shift,
    input  logic [W-1:0]  din,
    input  logic [DW-1:0] sin,
    output logic [W-1:0]  q
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= '0;
        else if (load)
            q_r <= din;
        else if (shift)
            q_r <= {sin, q_r[W-1:DW]};
    end

    assign q = q_r;
endmodule

// File: rtl/bcd_serial_ctrl.sv
module bcd_serial_ctrl
    import bcd_serial_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic shift,
    output logic busy,
    output logic done
);
    localparam int CW = (DIGITS > 1) ? $clog2(DIGITS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIGITS - 1);

    ser_state_t      state, state_nx;
    logic [CW-1:0]   cnt;

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // digit counter
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= '0;
        else if (shift)
            cnt <= cnt + 1'b1;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_RUN;
            ST_RUN:  if (cnt == LAST) state_nx = ST_DONE;
            ST_DONE: state_nx = start ? ST_RUN : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load  = 1'b0;
        shift = 1'b0;
        busy  = 1'b0;
        done  = 1'b0;
        unique case (state)
            ST_IDLE: load = start;
            ST_RUN: begin
                shift = 1'b1;
                busy  = 1'b1;
            end
            ST_DONE: begin
                load = start;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // R4: completion follows the final run cycle
    assert_done_after_run_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && $past(cnt) == LAST));

    // R4: completion lasts a single cycle
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: a start during a run neither restarts the count nor ends the run
    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && start && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));

    // R3: a run begins only from an accepted start
    assert_run_entry_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(start) && !$past(busy)));
endmodule

// File: rtl/bcd_serial_adder.sv
module bcd_serial_adder
    import bcd_serial_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W = DIGITS * DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         carry_in,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] sum,
    output logic         carry_out
);
    logic          load, shift;
    logic [W-1:0]  a_q, b_q, r_q;
    logic [DW-1:0] dig_s;
    logic          dig_c;
    logic          carry_q;

    bcd_serial_ctrl #(.DIGITS(DIGITS)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .load (load),
        .shift(shift),
        .busy (busy),
        .done (done)
    );

    bcd_shift_reg #(.DIGITS(DIGITS)) u_opa_sr (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .din(opa), .sin('0), .q(a_q)
    );

    bcd_shift_reg #(.DIGITS(DIGITS)) u_opb_sr (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .din(opb), .sin('0), .q(b_q)
    );

    bcd_digit_stage u_stage (
        .a   (a_q[DW-1:0]),
        .b   (b_q[DW-1:0]),
        .cin (carry_q),
        .s   (dig_s),
        .cout(dig_c)
    );

    // result digits enter at the top and move down
    bcd_shift_reg #(.DIGITS(DIGITS)) u_res_sr (
        .clk(clk), .rst(rst), .load(1'b0), .shift(shift),
        .din('0), .sin(dig_s), .q(r_q)
    );

    // inter-digit carry flip-flop
    always_ff @(posedge clk) begin
        if (rst)
            carry_q <= 1'b0;
        else if (load)
            carry_q <= carry_in;
        else if (shift)
            carry_q <= dig_c;
    end

    assign sum       = r_q;
    assign carry_out = carry_q;

    // R5: written digits stay decimal (operand digits assumed 0..9)
    assert_digit_range_R5: assert property (@(posedge clk) disable iff (rst)
        shift |-> (dig_s <= 4'd9));

    // R7: idle result is held
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(sum) && $stable(carry_out)));

    // R9: carry register takes carry_in on an accepted start
    assert_carry_seed_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (carry_out == $past(carry_in)));
endmodule

// File: tb/bcd_serial_adder_bench.sv
module bcd_serial_adder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 2;
    localparam int W   = 4 * N;
    localparam int MOD = 100;   // 10**N

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         carry_in = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         busy, done, carry_out;
    logic [W-1:0] sum;

    int nchk  = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_serial_adder #(.DIGITS(N)) u_bcd_serial_adder (
        .clk(clk), .rst(rst), .start(start), .carry_in(carry_in),
        .opa(opa), .opb(opb), .busy(busy), .done(done),
        .sum(sum), .carry_out(carry_out)
    );

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] r;
        int t;
        r = '0;
        t = v;
        for (int k = 0; k < N; k++) begin
            r[4*k +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    // start an addition at a negedge, return busy cycle count at done
    task automatic run_add(input int a, input int b, input bit c, output int cyc);
        int guard;
        opa = to_bcd(a);
        opb = to_bcd(b);
        carry_in = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        guard = 0;
        while (!done && guard < 50) begin
            if (busy) cyc++;
            guard++;
            @(negedge clk);
        end
        if (guard >= 50) check(1'b0, "R4 done never seen", 0, 1);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int cyc, tot, ref_sum;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        check(!busy && !done, "R8 busy/done after reset", {busy, done}, 0);
        check(sum == '0 && !carry_out, "R8 sum/carry after reset", int'(sum), 0);

        // R1 R2 R3 R4 R9: full sweep of two-digit operands, both carry-ins
        for (int a = 0; a < MOD; a++) begin
            for (int b = 0; b < MOD; b++) begin
                for (int c = 0; c < 2; c++) begin
                    run_add(a, b, c[0], cyc);
                    tot = a + b + c;
                    check(sum == to_bcd(tot % MOD), "R1 R9 sum digits", int'(sum), int'(to_bcd(tot % MOD)));
                    check(carry_out == (tot >= MOD), "R2 final carry", int'(carry_out), int'(tot >= MOD));
                    check(cyc == N, "R3 busy length", cyc, N);
                    @(negedge clk);
                    check(!done, "R4 done one cycle", int'(done), 0);
                end
            end
        end

        // R5: 99 + 99 + 1 -> every digit 9+9+1 = 19
        run_add(99, 99, 1'b1, cyc);
        check(sum == to_bcd(99) && carry_out, "R5 correction with carry", int'(sum), int'(to_bcd(99)));
        // R5: 05 + 05 -> low digit 10 folds to 0, carry into tens
        run_add(5, 5, 1'b0, cyc);
        check(sum == to_bcd(10), "R5 correction raw 10", int'(sum), int'(to_bcd(10)));

        // R7: result held through idle cycles
        ref_sum = int'(sum);
        repeat (5) @(negedge clk);
        check(int'(sum) == ref_sum && !carry_out, "R7 idle hold", int'(sum), ref_sum);

        // R6: start during busy is ignored
        opa = to_bcd(12); opb = to_bcd(34); carry_in = 1'b0;
        start = 1'b1;
        @(negedge clk);
        opa = to_bcd(77); opb = to_bcd(88); carry_in = 1'b1;  // start still high while busy
        cyc = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 50) begin
            if (busy) cyc++;
            @(negedge clk);
        end
        check(sum == to_bcd(46) && !carry_out, "R6 operands kept", int'(sum), int'(to_bcd(46)));
        check(cyc == N, "R6 run length kept", cyc, N);

        // R8: reset in the middle of a run
        opa = to_bcd(50); opb = to_bcd(60); carry_in = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && sum == '0 && !carry_out, "R8 mid-run reset",
              {busy, done, carry_out}, 0);
        repeat (N + 2) @(negedge clk);
        check(!done && !busy, "R8 no completion after reset", {busy, done}, 0);

        finish_run();
    end
endmodule